// File: doc/BRIEF.md
# Infrared Carrier Generator with Two-Pair FSK

This block produces the carrier waveform for an infrared remote-control transmitter. The carrier is a square wave. Its high time and its low time are each a count of input clocks. Two pairs of counts are held in registers: a primary pair and a secondary pair. In timer mode the primary pair alone shapes every period. In FSK mode an external select input picks the pair for each period, so a modulator can shift the carrier between two frequencies.

The waveform reaches the single output pin through a programmable polarity inversion. While the generator is disabled, the pin shows a latch bit that software writes, after the same inversion. Software uses this to drive the pin directly.

A small register port gives software access to the four counts, the latch and the polarity. Writes are synchronous. Reads return registered data one clock after the address is presented. The 8-bit word at address 0 holds three fields, and all three are updated by a single write.

Top module: `ircar_gen`

## Requirements
- R1: After synchronous reset, ir_out is 0 and all four registers read back as 0.
- R2: In timer mode (fsk_mode=0), every period is high for the primary high count and then low for the primary low count, counted in clocks. mod_sel has no effect in this mode.
- R3: In FSK mode (fsk_mode=1), a period uses the secondary pair when mod_sel=1 and the primary pair when mod_sel=0.
- R4: The pair is sampled once, at the clock edge that starts a period. If mod_sel changes during a period, only the next period is affected, so a period never takes its high time from one pair and its low time from the other.
- R5: A count of 0 behaves as a phase of one clock. The generator never stalls.
- R6: When the polarity bit is 1, ir_out is inverted. This applies both while the carrier runs and while the generator is idle.
- R7: While enable=0, ir_out equals the latch bit XOR the polarity bit. It reflects a write within two clocks. Re-enabling always starts a fresh period.
- R8: The register map has four addresses:
  - Address 0 holds the primary high word: bit 7 is the latch, bit 6 is the polarity, and bits 5:0 are the primary high count. One write to address 0 sets all three fields.
  - Address 1 is the primary low count.
  - Address 2 is the secondary high count.
  - Address 3 is the secondary low count.
- R9: A count written during a running phase does not change that phase. The new value is used from the next reload of that phase.
- R10: rd_data is valid one clock after rd_addr is presented.
  - Addresses 1 to 3 return the count in bits 5:0, with bits 7:6 at 0.
  - Address 0 returns the current latch in bit 7 and the polarity in bit 6.
- R11: Each period begins with its high phase. ir_out first reaches the active level on the second rising edge after enable is first sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic; also the carrier count clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the carrier when high; selects the latch path when low |
| fsk_mode | input | 1 | 1 = FSK mode, 0 = timer mode |
| mod_sel | input | 1 | Pair select from the modulator (1 = secondary pair) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| ir_out | output | 1 | Carrier output pin after polarity |

## Verification
Timer mode is checked with a full sweep of primary high and low counts from 0 to 4, while mod_sel is held at 1 and the secondary pair holds distinct values. Any leak from the secondary pair, or any zero-count stall, shows up as a wrong run length.

FSK mode is checked with several secondary-pair values, each measured against a primary pair of different lengths. In a further test, mod_sel flips in the middle of a period. That test separates sampling once per period from sampling on every phase reload.

A count rewritten in the middle of a high phase shows whether the new value is applied immediately or at the next reload. Latch and polarity writes are checked with the generator idle and with it running, which confirms that the inversion sits after the mux.

// File: rtl/ircar_pkg.sv
package ircar_pkg;
  localparam int NPAIR  = 2;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PHI = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PLO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SHI = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_SLO = 2'd3;

  typedef enum logic {
    PH_HIGH = 1'b0,
    PH_LOW  = 1'b1
  } phase_e;
endpackage

// File: rtl/ircar_regs.sv
module ircar_regs
  import ircar_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  hi_cnt [NPAIR],
  output logic [CNT_W-1:0]  lo_cnt [NPAIR],
  output logic              latch_q,
  output logic              pol_q
);
  localparam int LATCH_BIT = DATA_W - 1;
  localparam int POL_BIT   = DATA_W - 2;

  logic [DATA_W-1:0] rd_word;

  // address bit 1 picks the pair, bit 0 picks high or low
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        hi_cnt[p] <= '0;
        lo_cnt[p] <= '0;
      end else if (wr_en && (wr_addr[1] == 1'(p))) begin
        if (wr_addr[0]) lo_cnt[p] <= wr_data[CNT_W-1:0];
        else            hi_cnt[p] <= wr_data[CNT_W-1:0];
      end
    end
  end

  // the primary high word also carries latch and polarity
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= 1'b0;
      pol_q   <= 1'b0;
    end else if (wr_en && wr_addr == ADDR_PHI) begin
      latch_q <= wr_data[LATCH_BIT];
      pol_q   <= wr_data[POL_BIT];
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[CNT_W-1:0] = rd_addr[0] ? lo_cnt[rd_addr[1]] : hi_cnt[rd_addr[1]];
    if (rd_addr == ADDR_PHI) begin
      rd_word[LATCH_BIT] = latch_q;
      rd_word[POL_BIT]   = pol_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end
endmodule

// File: rtl/ircar_timer.sv
module ircar_timer
  import ircar_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             fsk_mode,
  input  logic             mod_sel,
  input  logic [CNT_W-1:0] hi_cnt [NPAIR],
  input  logic [CNT_W-1:0] lo_cnt [NPAIR],
  output logic             active,
  output logic             carrier,
  output logic             sel_q,
  output logic             start,
  output logic [CNT_W-1:0] rem
);
  phase_e     phase;
  logic       sel_now;
  logic       last;
  logic       flip_low;

  // a zero count runs for a single clock
  function automatic logic [CNT_W-1:0] eff(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign sel_now  = fsk_mode & mod_sel;
  assign last     = (rem == CNT_W'(1));
  assign start    = enable && (!active || (phase == PH_LOW && last));
  assign flip_low = active && (phase == PH_HIGH) && last;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      active  <= 1'b0;
      phase   <= PH_HIGH;
      rem     <= '0;
      carrier <= 1'b0;
      if (rst) sel_q <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      phase   <= PH_HIGH;
      sel_q   <= sel_now;
      rem     <= eff(hi_cnt[sel_now]);
      carrier <= 1'b1;
    end else if (flip_low) begin
      phase   <= PH_LOW;
      rem     <= eff(lo_cnt[sel_q]);
      carrier <= 1'b0;
    end else if (active) begin
      rem     <= rem - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ircar_drive.sv
module ircar_drive (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic carrier,
  input  logic latch,
  input  logic pol,
  output logic ir_out
);
  logic level;

  assign level = active ? carrier : latch;

  always_ff @(posedge clk) begin
    if (rst) ir_out <= 1'b0;
    else     ir_out <= level ^ pol;
  end
endmodule

// File: rtl/ircar_gen.sv
module ircar_gen
  import ircar_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              fsk_mode,
  input  logic              mod_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ir_out
);
  logic [CNT_W-1:0] hi_cnt [NPAIR];
  logic [CNT_W-1:0] lo_cnt [NPAIR];
  logic             latch_q;
  logic             pol_q;
  logic             tmr_active;
  logic             tmr_carrier;
  logic             tmr_sel;
  logic             tmr_start;
  logic [CNT_W-1:0] tmr_rem;

  ircar_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
    .latch_q(latch_q), .pol_q(pol_q)
  );

  ircar_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst),
    .enable(enable), .fsk_mode(fsk_mode), .mod_sel(mod_sel),
    .hi_cnt(hi_cnt), .lo_cnt(lo_cnt),
    .active(tmr_active), .carrier(tmr_carrier), .sel_q(tmr_sel),
    .start(tmr_start), .rem(tmr_rem)
  );

  ircar_drive u_drive (
    .clk(clk), .rst(rst),
    .active(tmr_active), .carrier(tmr_carrier),
    .latch(latch_q), .pol(pol_q),
    .ir_out(ir_out)
  );
endmodule

// File: rtl/ircar_chk.sv
module ircar_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             fsk_mode,
  input logic             ir_out,
  input logic             active,
  input logic             carrier,
  input logic             sel,
  input logic             start,
  input logic [CNT_W-1:0] rem
);
  // R1: the output is low on the cycle after a reset edge
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !ir_out);

  // R5: a running phase never has an empty count
  a_r5_no_stall: assert property (@(posedge clk) disable iff (rst)
    active |-> rem != '0);

  // R11: every period opens with the high phase
  a_r11_high_first: assert property (@(posedge clk) disable iff (rst)
    start |=> carrier);

  // R2: timer mode only ever picks the primary pair
  a_r2_timer_primary: assert property (@(posedge clk) disable iff (rst)
    (start && !fsk_mode) |=> !sel);

  // R4: the sampled pair holds for the whole period
  a_r4_pair_hold: assert property (@(posedge clk) disable iff (rst)
    (active && !start) |=> $stable(sel));
endmodule

bind ircar_gen ircar_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fsk_mode(fsk_mode), .ir_out(ir_out),
  .active(tmr_active), .carrier(tmr_carrier), .sel(tmr_sel),
  .start(tmr_start), .rem(tmr_rem)
);

// File: tb/ircar_gen_test.sv
module ircar_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       fsk_mode = 1'b0;
  logic       mod_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ir_out;

  int  total = 0;
  int  bad = 0;
  logic pol_b = 1'b0;

  ircar_gen uut (
    .clk(clk), .rst(rst), .enable(enable), .fsk_mode(fsk_mode),
    .mod_sel(mod_sel), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ir_out(ir_out)
  );

  always #10 clk = ~clk;

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  function automatic int lvl();
    return int'(ir_out ^ pol_b);
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic wait_rise();
    int prev;
    prev = lvl();
    forever begin
      @(negedge clk);
      if (prev == 0 && lvl() == 1) break;
      prev = lvl();
    end
  endtask

  // called on the sample where the active level first appears
  task automatic count_rest(output int h, output int l);
    h = 1;
    forever begin
      @(negedge clk);
      if (lvl() == 1) h++; else break;
    end
    l = 1;
    forever begin
      @(negedge clk);
      if (lvl() == 0) l++; else break;
    end
  endtask

  task automatic run_period(output int h, output int l);
    @(negedge clk);
    enable = 1'b1;
    wait_rise();
    count_rest(h, l);
    enable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int v, h, l;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check_eq("R1 ir_out after reset", int'(ir_out), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check_eq("R1 register after reset", v, 0);
    end

    // R8 R10 register map and readback
    wr(2'd0, 8'hC5); rd(2'd0, v); check_eq("R8 addr0 readback", v, 8'hC5);
    wr(2'd2, 8'hFF); rd(2'd2, v); check_eq("R10 addr2 upper bits zero", v, 8'h3F);
    wr(2'd1, 8'h2A); rd(2'd1, v); check_eq("R10 addr1 readback", v, 8'h2A);
    wr(2'd3, 8'h41); rd(2'd3, v); check_eq("R10 addr3 upper bits zero", v, 8'h01);

    // R7 R6 latch path while idle
    repeat (2) @(negedge clk);
    check_eq("R7 latch1 pol1 idle", int'(ir_out), 0);
    wr(2'd0, 8'h80); repeat (2) @(negedge clk);
    check_eq("R7 latch1 pol0 idle", int'(ir_out), 1);
    rd(2'd0, v); check_eq("R10 latch bit readback", v, 8'h80);
    wr(2'd0, 8'h40); repeat (2) @(negedge clk);
    check_eq("R6 latch0 pol1 idle", int'(ir_out), 1);
    wr(2'd0, 8'h00); repeat (2) @(negedge clk);
    check_eq("R7 latch0 pol0 idle", int'(ir_out), 0);

    // R11 first active level on second edge after enable
    wr(2'd0, 8'd4); wr(2'd1, 8'd4);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk); check_eq("R11 one edge after enable", int'(ir_out), 0);
    @(negedge clk); check_eq("R11 two edges after enable", int'(ir_out), 1);
    enable = 1'b0;
    repeat (3) @(negedge clk);

    // R2 R5 timer sweep; secondary pair set to distinct lengths
    wr(2'd2, 8'd9); wr(2'd3, 8'd9);
    fsk_mode = 1'b0; mod_sel = 1'b1;
    for (int hh = 0; hh < 5; hh++) begin
      for (int ll = 0; ll < 5; ll++) begin
        wr(2'd0, 8'(hh)); wr(2'd1, 8'(ll));
        run_period(h, l);
        check_eq((hh == 0) ? "R5 zero high count" : "R2 timer high", h, eff(hh));
        check_eq((ll == 0) ? "R5 zero low count" : "R2 timer low", l, eff(ll));
      end
    end

    // R3 FSK pair select
    fsk_mode = 1'b1;
    wr(2'd0, 8'd2); wr(2'd1, 8'd3);
    for (int s = 0; s < 4; s++) begin
      wr(2'd2, 8'(s + 4)); wr(2'd3, 8'(7 - s));
      mod_sel = 1'b1;
      run_period(h, l);
      check_eq("R3 secondary high", h, s + 4);
      check_eq("R3 secondary low", l, 7 - s);
    end
    mod_sel = 1'b0;
    run_period(h, l);
    check_eq("R3 primary high", h, 2);
    check_eq("R3 primary low", l, 3);

    // R4 mod_sel flips during a period
    wr(2'd2, 8'd5); wr(2'd3, 8'd7);
    mod_sel = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    wait_rise();
    mod_sel = 1'b0;
    count_rest(h, l);
    check_eq("R4 current period high", h, 5);
    check_eq("R4 current period low", l, 7);
    count_rest(h, l);
    check_eq("R4 next period high", h, 2);
    check_eq("R4 next period low", l, 3);
    enable = 1'b0;
    repeat (3) @(negedge clk);

    // R9 count rewritten mid-phase
    fsk_mode = 1'b0;
    wr(2'd0, 8'd10); wr(2'd1, 8'd10);
    @(negedge clk);
    enable = 1'b1;
    wait_rise();
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd3;
    h = 1;
    @(negedge clk);
    wr_en = 1'b0;
    if (lvl() == 1) h++;
    while (lvl() == 1) begin
      @(negedge clk);
      if (lvl() == 1) h++;
    end
    check_eq("R9 running phase unchanged", h, 10);
    wait_rise();
    count_rest(h, l);
    check_eq("R9 new high used at reload", h, 3);
    check_eq("R9 low unchanged", l, 10);
    enable = 1'b0;
    repeat (3) @(negedge clk);

    // R6 polarity while running
    wr(2'd0, 8'h45); wr(2'd1, 8'd2);
    pol_b = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R6 idle inverted", int'(ir_out), 1);
    run_period(h, l);
    check_eq("R6 inverted high time", h, 5);
    check_eq("R6 inverted low time", l, 2);

    finish_up();
  end
endmodule